// File: doc/BRIEF.md
# Boot Region Lockout Guard

This block filters program and erase requests for a byte-addressed flash array that has two fixed boot regions, one at the bottom of the address space and one at the top. It watches the decoded bus write events for a seven-write command sequence. The last write of that sequence picks which region gets locked. When the sequence completes, the block sets a sticky lock bit for the chosen region.

From then on the block refuses program cycles whose target address falls inside a locked region. Addresses outside the locked regions stay programmable. As soon as either lock is set, it also refuses whole-array erase. The program controller presents a target address and reads two combinational qualifiers. A refused program cycle still runs the controller's busy timer, but the controller leaves the array untouched.

Top module: `bootlock_guard`

## Requirements
- R1: After reset neither region is locked, `pgm_ok` is 1 for every `tgt_addr`, and `erase_ok` is 1.
- R2: The lock sequence is seven write events that match on address bits [14:0] and data, in this order: 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0xA0, 0x5555/0x80, 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x40. When the final write has address bit 16 equal to 0, the low region is locked, starting from the cycle after that write.
- R3: When the final write has address bit 16 equal to 1, the high region is locked instead. Each lock is set only by its own completed sequence.
- R4: `pgm_ok` is 0 exactly when `tgt_addr` lies in a locked region. The low region is 0x00000–0x01FFF (bits [16:13] all 0). The high region is 0x1E000–0x1FFFF (bits [16:13] all 1).
- R5: `erase_ok` is 0 whenever at least one region is locked.
- R6: A write event that does not match the expected step sends the tracker back to its first step and sets no lock. A later complete sequence still works.
- R7: Lock bits are sticky. No write sequence clears them; only reset does. Locking the second region keeps the first one locked.
- R8: Cycles with `wr_en` low do not advance or reset the sequence, whatever the address and data inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears both locks |
| wr_en | input | 1 | One-cycle pulse per decoded bus write |
| wr_addr | input | 17 | Address of the bus write |
| wr_data | input | 8 | Data of the bus write |
| tgt_addr | input | 17 | Target address of the pending program cycle |
| pgm_ok | output | 1 | Program to `tgt_addr` is allowed |
| erase_ok | output | 1 | Whole-array erase is allowed |

## Verification
A tracker stuck on the wrong step is only visible at the ports when a sequence completes. Depending on the fault, the lock either never rises or rises early. So every abort point is followed by the remaining steps, and then by probes of both regions and the erase qualifier. A wrong lock bit, or a wrong region decode, changes `pgm_ok` for whole 8 KB ranges as soon as the next address is presented. A sweep across every sector base and every sector end, for each combination of locks, therefore exposes it within one vector.

// File: rtl/bootlock_pkg.sv
package bootlock_pkg;
    localparam int STEPS  = 7;
    localparam int CMD_AW = 15;
    localparam int STEP_W = $clog2(STEPS);

    typedef logic [STEP_W-1:0] step_t;

    typedef struct packed {
        logic [CMD_AW-1:0] addr;
        logic [7:0]        data;
    } cmd_t;

    function automatic cmd_t step_cmd(input step_t idx);
        cmd_t c;
        case (idx)
            step_t'(0): c = '{addr: 15'h5555, data: 8'hAA};
            step_t'(1): c = '{addr: 15'h2AAA, data: 8'h55};
            step_t'(2): c = '{addr: 15'h5555, data: 8'hA0};
            step_t'(3): c = '{addr: 15'h5555, data: 8'h80};
            step_t'(4): c = '{addr: 15'h5555, data: 8'hAA};
            step_t'(5): c = '{addr: 15'h2AAA, data: 8'h55};
            default:    c = '{addr: 15'h5555, data: 8'h40};
        endcase
        return c;
    endfunction
endpackage

// File: rtl/bootlock_seq.sv
module bootlock_seq
    import bootlock_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              set_lo,
    output logic              set_hi
);
    localparam step_t LAST = step_t'(STEPS - 1);

    typedef struct packed {
        step_t step;
    } seq_t;

    seq_t seq_d, seq_q;
    cmd_t exp_cmd;
    logic hit;

    always_comb begin
        exp_cmd = step_cmd(seq_q.step);
        hit     = (wr_addr[CMD_AW-1:0] == exp_cmd.addr) && (wr_data == exp_cmd.data);
        seq_d   = seq_q;
        set_lo  = 1'b0;
        set_hi  = 1'b0;
        if (wr_en) begin
            if (!hit) begin
                seq_d.step = '0;
            end else if (seq_q.step == LAST) begin
                seq_d.step = '0;
                set_lo     = ~wr_addr[ADDR_W-1];
                set_hi     =  wr_addr[ADDR_W-1];
            end else begin
                seq_d.step = seq_q.step + step_t'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    AST_SET_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({set_lo, set_hi}));                                          // R3
    AST_MISS_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !hit) |=> (seq_q.step == '0));                              // R6
    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(seq_q.step));                                      // R8
    AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.step <= LAST);                                                  // R2
endmodule

// File: rtl/bootlock_regs.sv
module bootlock_regs (
    input  logic clk,
    input  logic rst_n,
    input  logic set_lo,
    input  logic set_hi,
    output logic lock_lo,
    output logic lock_hi
);
    typedef struct packed {
        logic lo;
        logic hi;
    } lk_t;

    lk_t lk_d, lk_q;

    always_comb begin
        lk_d    = lk_q;
        lk_d.lo = lk_q.lo | set_lo;
        lk_d.hi = lk_q.hi | set_hi;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lk_q <= '0;
        else        lk_q <= lk_d;
    end

    assign lock_lo = lk_q.lo;
    assign lock_hi = lk_q.hi;

    AST_LO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        lk_q.lo |=> lk_q.lo);                                                 // R7
    AST_HI_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        lk_q.hi |=> lk_q.hi);                                                 // R7
    AST_LO_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (!lk_q.lo && !set_lo) |=> !lk_q.lo);                                  // R2
    AST_HI_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (!lk_q.hi && !set_hi) |=> !lk_q.hi);                                  // R3
endmodule

// File: rtl/bootlock_qual.sv
module bootlock_qual #(
    parameter int ADDR_W   = 17,
    parameter int REGION_W = 13
) (
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic              lock_lo,
    input  logic              lock_hi,
    output logic              pgm_ok,
    output logic              erase_ok
);
    localparam int TAG_W = ADDR_W - REGION_W;

    logic [1:0] in_reg;
    logic [1:0] locks;

    assign locks = {lock_hi, lock_lo};

    for (genvar r = 0; r < 2; r++) begin : g_region
        localparam logic [TAG_W-1:0] TAG = (r == 0) ? '0 : '1;
        assign in_reg[r] = (tgt_addr[ADDR_W-1:REGION_W] == TAG);
    end

    assign pgm_ok   = ~|(in_reg & locks);
    assign erase_ok = ~|locks;
endmodule

// File: rtl/bootlock_guard.sv
module bootlock_guard #(
    parameter int ADDR_W   = 17,
    parameter int REGION_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] tgt_addr,
    output logic              pgm_ok,
    output logic              erase_ok
);
    logic set_lo, set_hi;
    logic lock_lo, lock_hi;

    bootlock_seq #(.ADDR_W(ADDR_W)) i_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .set_lo(set_lo), .set_hi(set_hi)
    );

    bootlock_regs i_regs (
        .clk(clk), .rst_n(rst_n), .set_lo(set_lo), .set_hi(set_hi),
        .lock_lo(lock_lo), .lock_hi(lock_hi)
    );

    bootlock_qual #(.ADDR_W(ADDR_W), .REGION_W(REGION_W)) i_qual (
        .tgt_addr(tgt_addr), .lock_lo(lock_lo), .lock_hi(lock_hi),
        .pgm_ok(pgm_ok), .erase_ok(erase_ok)
    );

    AST_ERASE_AFTER_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (set_lo || set_hi) |=> !erase_ok);                                    // R5
    AST_LOW_VETO: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_lo && (tgt_addr[ADDR_W-1:REGION_W] == '0)) |-> !pgm_ok);        // R4
    AST_HIGH_VETO: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_hi && (tgt_addr[ADDR_W-1:REGION_W] == '1)) |-> !pgm_ok);        // R4
endmodule

// File: tb/test_bootlock_guard.sv
module test_bootlock_guard;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [16:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [16:0] tgt_addr = '0;
    logic        pgm_ok, erase_ok;

    int n_vec = 0;
    int n_bad = 0;

    bootlock_guard i_bootlock_guard (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .tgt_addr(tgt_addr), .pgm_ok(pgm_ok), .erase_ok(erase_ok)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [22:0] step_of(input int k);
        case (k)
            0: return {15'h5555, 8'hAA};
            1: return {15'h2AAA, 8'h55};
            2: return {15'h5555, 8'hA0};
            3: return {15'h5555, 8'h80};
            4: return {15'h5555, 8'hAA};
            5: return {15'h2AAA, 8'h55};
            default: return {15'h5555, 8'h40};
        endcase
    endfunction

    function automatic logic exp_pgm(input logic [16:0] a, input logic lo, input logic hi);
        return !((a[16:13] == 4'h0) && lo) && !((a[16:13] == 4'hF) && hi);
    endfunction

    task automatic check(input string tag, input logic got, input logic exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b (tgt_addr=%h)", tag, got, exp, tgt_addr);
        end
    endtask

    task automatic wr(input logic [16:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = 17'h0A5A5; wr_data = 8'h3C;
    endtask

    task automatic wr_step(input int k, input logic sel);
        logic [22:0] s;
        s = step_of(k);
        wr({sel, 1'b0, s[22:8]}, s[7:0]);
    endtask

    task automatic full_seq(input logic sel);
        for (int k = 0; k < 7; k++) wr_step(k, sel);
    endtask

    task automatic sweep(input string tag, input logic lo, input logic hi);
        @(negedge clk);
        for (int s = 0; s < 1024; s++) begin
            tgt_addr = 17'(s * 128);
            #1 check(tag, pgm_ok, exp_pgm(tgt_addr, lo, hi));
            tgt_addr = 17'(s * 128 + 127);
            #1 check(tag, pgm_ok, exp_pgm(tgt_addr, lo, hi));
        end
        check({tag, " R5 erase"}, erase_ok, !(lo || hi));
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    initial begin
        do_reset();
        // R1: reset state
        sweep("R1 reset", 1'b0, 1'b0);

        // R8 and R3: high lock with idle cycles between steps carrying garbage
        for (int k = 0; k < 7; k++) begin
            wr_step(k, 1'b1);
            @(negedge clk); wr_addr = 17'h05555; wr_data = 8'h00;
            @(negedge clk);
        end
        sweep("R3/R8 high lock", 1'b0, 1'b1);

        // R7: stray writes and a low lock keep the high lock
        wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h00);
        sweep("R7 stray writes", 1'b0, 1'b1);
        full_seq(1'b0);
        sweep("R7/R2 both locked", 1'b1, 1'b1);

        // R6: abort at each step, then the remaining steps must not lock
        for (int k = 0; k < 7; k++) begin
            logic [22:0] s;
            do_reset();
            for (int j = 0; j < k; j++) wr_step(j, 1'b0);
            s = step_of(k);
            wr({2'b00, s[22:8]}, s[7:0] ^ 8'h01);
            for (int j = k + 1; j < 7; j++) wr_step(j, 1'b0);
            @(negedge clk);
            tgt_addr = 17'h00000; #1 check("R6 abort low", pgm_ok, 1'b1);
            tgt_addr = 17'h1FFFF; #1 check("R6 abort high", pgm_ok, 1'b1);
            check("R6 abort erase", erase_ok, 1'b1);
        end
        // R6: address mismatch at final step
        for (int j = 0; j < 6; j++) wr_step(j, 1'b0);
        wr(17'h02AAA, 8'h40);
        @(negedge clk); check("R6 addr miss erase", erase_ok, 1'b1);

        // R2 and R4: low lock only, with region edges
        full_seq(1'b0);
        sweep("R2/R4 low lock", 1'b1, 1'b0);
        @(negedge clk);
        tgt_addr = 17'h01FFF; #1 check("R4 low edge in", pgm_ok, 1'b0);
        tgt_addr = 17'h02000; #1 check("R4 low edge out", pgm_ok, 1'b1);
        tgt_addr = 17'h1E000; #1 check("R4 high unlocked", pgm_ok, 1'b1);
        full_seq(1'b1);
        @(negedge clk);
        tgt_addr = 17'h1DFFF; #1 check("R4 high edge out", pgm_ok, 1'b1);
        tgt_addr = 17'h1E000; #1 check("R4 high edge in", pgm_ok, 1'b0);
        tgt_addr = 17'h00000; #1 check("R7 low kept", pgm_ok, 1'b0);

        report();
    end
endmodule